// File: doc/BRIEF.md
# SCSI DMA Byte Handshake Engine

This block runs the automatic, asynchronous per-byte handshake on a SCSI bus while a DMA transfer is in progress. It works in either bus role. As target it raises REQ for each byte and waits for the initiator's ACK. As initiator it answers the target's REQ with ACK. It moves bytes in both directions through a single holding register. On receive it captures the bus data when the peer's strobe asserts. On send it drives the buffered byte until the peer has acknowledged it.

On the host side the engine asks for service through a DMA request line, or through a ready line when block mode is selected. A host access is DACK together with a read or write strobe, and it needs no address. An end-of-process input stops the transfer cleanly. A mode bit enables DMA. One of three start strobes picks the direction: send, receive as target, or receive as initiator. All bus inputs pass through a two-stage synchroniser before the handshake logic uses them. The signals here are active high; the pad logic outside the block handles bus polarity.

Top module: `scsi_dma_hs`

## Requirements
- R1: In the target role, REQ is raised once per byte and dropped only after ACK has been seen asserted. The next REQ waits until ACK has been seen deasserted.
- R2: In the initiator role, ACK is raised only after REQ has been seen asserted, and ACK stays up until REQ has been seen deasserted.
- R3: Receiving as initiator, the byte on `bus_data_in` is captured when REQ is first seen asserted. Receiving as target, it is captured when ACK is first seen asserted. Later changes of the bus data do not alter the captured byte, which appears on `host_rdata`.
- R4: For a send, the host request is asserted in the cycle after an accepted start and whenever the holding register is empty. For a receive, it is asserted whenever the register holds a byte.
- R5: DACK with `wr_stb` (send) or `rd_stb` (receive) accesses the holding register without any address. The host request is low in the following cycle.
- R6: With `cfg_block` = 1 the request appears on `ready` and `drq` stays 0. With `cfg_block` = 0 it appears on `drq` and `ready` stays 0.
- R7: `eop` counts only together with DACK and a strobe. A valid EOP stops all further host requests and new bus bytes, but a byte already written for sending is still sent. With `eop_irq_en` = 1 it sets `irq_eop`. An EOP without DACK has no effect.
- R8: A valid EOP leaves `dma_on` set. BSY seen inactive clears `dma_on`, aborts the transfer and drops REQ/ACK and the host request within four cycles of `bsy_in` falling.
- R9: Start strobes are ignored while `dma_on` is 0. A target-receive start is ignored in the initiator role (`cfg_target` = 0), and an initiator-receive start is ignored in the target role.
- R10: `req_out` is never asserted while `cfg_target` = 0, and `ack_out` is never asserted while `cfg_target` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_target | input | 1 | 1 = target role, 0 = initiator role |
| cfg_block | input | 1 | 1 = host throttled by `ready` instead of `drq` |
| eop_irq_en | input | 1 | Enables `irq_eop` on a valid EOP |
| mode_wr | input | 1 | Write pulse for the DMA enable bit |
| mode_val | input | 1 | Value written to the DMA enable bit |
| start_send | input | 1 | Start a send transfer |
| start_trecv | input | 1 | Start a receive as target |
| start_irecv | input | 1 | Start a receive as initiator |
| dack | input | 1 | DMA acknowledge |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| eop | input | 1 | End of process |
| host_wdata | input | DATA_W | Byte written by the host |
| host_rdata | output | DATA_W | Byte read by the host |
| drq | output | 1 | DMA request |
| ready | output | 1 | Block-mode ready |
| irq_eop | output | 1 | End-of-DMA interrupt |
| dma_on | output | 1 | DMA enable bit |
| req_in | input | 1 | REQ seen on the bus |
| ack_in | input | 1 | ACK seen on the bus |
| bsy_in | input | 1 | BSY seen on the bus |
| bus_data_in | input | DATA_W | Bus data in |
| bus_data_out | output | DATA_W | Bus data out |
| bus_drive | output | 1 | Enable for the bus data drivers |
| req_out | output | 1 | REQ driven by this block |
| ack_out | output | 1 | ACK driven by this block |

## Verification
A handshake state that is out of step shows up on the bus first. A REQ or ACK that drops before the opposite strobe is seen, or one that never releases, is visible within two to three cycles of the peer's edge. The peer model then also receives a wrong or repeated byte, which the scoreboard reports. A wrong holding-register flag appears at the host port within one cycle as a request that stays high after an access, or that never arrives. Stale DMA-enable or EOP state shows up as host requests after EOP, or after BSY is lost, within four cycles.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  typedef enum logic [1:0] {XFER_NONE, XFER_SEND, XFER_TRECV, XFER_IRECV} xfer_t;
  typedef enum logic [2:0] {HS_IDLE, HS_T_REQ, HS_T_REL, HS_I_WAIT, HS_I_ACK} hs_state_t;

  // a transfer kind may start only in the role that owns its strobe
  function automatic logic start_allowed(input logic is_target, input xfer_t kind);
    case (kind)
      XFER_SEND:  return 1'b1;
      XFER_TRECV: return is_target;
      XFER_IRECV: return !is_target;
      default:    return 1'b0;
    endcase
  endfunction

  // host service needed: empty buffer on send, full buffer on receive
  function automatic logic host_wants(input xfer_t kind, input logic full, input logic eop_seen);
    case (kind)
      XFER_SEND:              return !full && !eop_seen;
      XFER_TRECV, XFER_IRECV: return full && !eop_seen;
      default:                return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_host_if.sv
module hs_host_if
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  xfer_t             kind,
  input  logic              block_mode,
  input  logic              eop_irq_en,
  input  logic              dack,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              eop,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bus_load,
  input  logic [DATA_W-1:0] bus_word,
  input  logic              bus_take,
  output logic [DATA_W-1:0] buf_q,
  output logic              buf_full,
  output logic              eop_seen,
  output logic              eop_valid,
  output logic              drq,
  output logic              ready,
  output logic              irq_eop
);
  logic host_wr_acc, host_rd_acc, host_req;

  assign host_wr_acc = active && (kind == XFER_SEND) && dack && wr_stb;
  assign host_rd_acc = active && (kind != XFER_SEND) && dack && rd_stb;
  assign eop_valid   = active && eop && dack && (rd_stb || wr_stb);
  assign host_req    = active && host_wants(kind, buf_full, eop_seen);
  assign drq         = host_req && !block_mode;
  assign ready       = host_req && block_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      eop_seen <= 1'b0;
      irq_eop  <= 1'b0;
    end else if (clr) begin
      buf_full <= 1'b0;
      eop_seen <= 1'b0;
      irq_eop  <= 1'b0;
    end else begin
      if (bus_load) begin
        buf_q    <= bus_word;
        buf_full <= 1'b1;
      end
      if (bus_take) buf_full <= 1'b0;
      if (host_wr_acc) begin
        buf_q    <= wdata;
        buf_full <= 1'b1;
      end
      if (host_rd_acc) buf_full <= 1'b0;
      if (eop_valid) begin
        eop_seen <= 1'b1;
        if (eop_irq_en) irq_eop <= 1'b1;
      end
    end
  end

  // R5: a serviced request is gone in the next cycle
  assert_access_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && dack && (wr_stb || rd_stb) && !clr) |=> !host_req)
    else $error("host request survived an access");

  // R7: after a valid EOP the host is not asked again
  assert_eop_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && !clr) |=> !(drq || ready))
    else $error("host request after EOP");
endmodule

// File: rtl/hs_bus_fsm.sv
module hs_bus_fsm
  import scsi_dma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  active,
  input  xfer_t kind,
  input  logic  is_target,
  input  logic  buf_full,
  input  logic  eop_seen,
  input  logic  req_s,
  input  logic  ack_s,
  output logic  req_o,
  output logic  ack_o,
  output logic  bus_load,
  output logic  bus_take
);
  hs_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    bus_load = 1'b0;
    bus_take = 1'b0;
    case (state)
      HS_IDLE: begin
        if (active) begin
          case (kind)
            XFER_SEND:  if (buf_full) state_nx = is_target ? HS_T_REQ : HS_I_WAIT;
            XFER_TRECV: if (!buf_full && !eop_seen && is_target) state_nx = HS_T_REQ;
            XFER_IRECV: if (!buf_full && !eop_seen && !is_target) state_nx = HS_I_WAIT;
            default: ;
          endcase
        end
      end
      HS_T_REQ: if (ack_s) begin
        bus_take = (kind == XFER_SEND);
        bus_load = (kind == XFER_TRECV);
        state_nx = HS_T_REL;
      end
      HS_T_REL: if (!ack_s) state_nx = HS_IDLE;
      HS_I_WAIT: if (req_s) begin
        bus_load = (kind == XFER_IRECV);
        state_nx = HS_I_ACK;
      end
      HS_I_ACK: if (!req_s) begin
        bus_take = (kind == XFER_SEND);
        state_nx = HS_IDLE;
      end
      default: state_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 state <= HS_IDLE;
    else if (clr || !active)    state <= HS_IDLE;
    else                        state <= state_nx;
  end

  assign req_o = (state == HS_T_REQ) && is_target;
  assign ack_o = (state == HS_I_ACK) && !is_target;

  // R1: REQ is released only once ACK has been seen
  assert_req_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_o) && is_target && $past(is_target) && !$past(clr) && $past(active)) |-> $past(ack_s))
    else $error("REQ dropped without ACK");

  // R2: ACK rises only on a seen REQ and falls only once REQ is seen low
  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_o) && $stable(is_target)) |-> $past(req_s))
    else $error("ACK raised without REQ");
  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_o) && !is_target && !$past(is_target) && !$past(clr) && $past(active)) |-> !$past(req_s))
    else $error("ACK dropped while REQ high");
endmodule

// File: rtl/scsi_dma_hs.sv
module scsi_dma_hs
  import scsi_dma_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_target,
  input  logic              cfg_block,
  input  logic              eop_irq_en,
  input  logic              mode_wr,
  input  logic              mode_val,
  input  logic              start_send,
  input  logic              start_trecv,
  input  logic              start_irecv,
  input  logic              dack,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              eop,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              drq,
  output logic              ready,
  output logic              irq_eop,
  output logic              dma_on,
  input  logic              req_in,
  input  logic              ack_in,
  input  logic              bsy_in,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_drive,
  output logic              req_out,
  output logic              ack_out
);
  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] sync_q;
  logic req_s, ack_s, bsy_s, bus_free;
  xfer_t start_kind, kind;
  logic  start_acc, active;
  logic  buf_full, eop_seen, eop_valid, bus_load, bus_take;
  logic [DATA_W-1:0] buf_q;

  hs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bsy_in, ack_in, req_in}), .q(sync_q)
  );
  assign {bsy_s, ack_s, req_s} = sync_q;
  assign bus_free = !bsy_s;

  always_comb begin
    if (start_send)       start_kind = XFER_SEND;
    else if (start_trecv) start_kind = XFER_TRECV;
    else if (start_irecv) start_kind = XFER_IRECV;
    else                  start_kind = XFER_NONE;
  end
  assign start_acc = dma_on && !bus_free && start_allowed(cfg_target, start_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dma_on <= 1'b0;
    else if (bus_free) dma_on <= 1'b0;
    else if (mode_wr)  dma_on <= mode_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      kind   <= XFER_NONE;
    end else if (bus_free || !dma_on) begin
      active <= 1'b0;
    end else if (start_acc) begin
      active <= 1'b1;
      kind   <= start_kind;
    end
  end

  hs_host_if #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .clr(bus_free || start_acc), .active(active),
    .kind(kind), .block_mode(cfg_block), .eop_irq_en(eop_irq_en),
    .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb), .eop(eop), .wdata(host_wdata),
    .bus_load(bus_load), .bus_word(bus_data_in), .bus_take(bus_take),
    .buf_q(buf_q), .buf_full(buf_full), .eop_seen(eop_seen), .eop_valid(eop_valid),
    .drq(drq), .ready(ready), .irq_eop(irq_eop)
  );

  hs_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .clr(bus_free || start_acc), .active(active),
    .kind(kind), .is_target(cfg_target), .buf_full(buf_full), .eop_seen(eop_seen),
    .req_s(req_s), .ack_s(ack_s), .req_o(req_out), .ack_o(ack_out),
    .bus_load(bus_load), .bus_take(bus_take)
  );

  assign host_rdata   = buf_q;
  assign bus_data_out = buf_q;
  assign bus_drive    = active && (kind == XFER_SEND) && buf_full;

  // R8: bus free drops the enable and the transfer
  assert_busfree_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |=> (!dma_on && !active))
    else $error("DMA survived bus free");
  // R8: a valid EOP keeps the enable bit
  assert_eop_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && bsy_s && !mode_wr) |=> dma_on)
    else $error("EOP cleared DMA enable");
  // R9: nothing runs while DMA is disabled
  assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on |=> !active)
    else $error("transfer active without DMA enable");
endmodule

// File: tb/scsi_dma_hs_test.sv
module scsi_dma_hs_test;
  logic clk = 0, rst_n = 0;
  logic cfg_target = 0, cfg_block = 0, eop_irq_en = 0, mode_wr = 0, mode_val = 0;
  logic start_send = 0, start_trecv = 0, start_irecv = 0;
  logic dack = 0, rd_stb = 0, wr_stb = 0, eop = 0;
  logic [7:0] host_wdata = 0, host_rdata, bus_data_in = 0, bus_data_out;
  logic drq, ready, irq_eop, dma_on, bus_drive, req_out, ack_out;
  logic req_in = 0, ack_in = 0, bsy_in = 0;

  int checks = 0, fails = 0, role_bad = 0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  scsi_dma_hs uut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor side: pop and compare one produced byte
  task automatic sb_pop(input logic [7:0] got, input string req);
    logic [7:0] e;
    if (exp_q.size() == 0) begin chk(0, req, "unexpected byte", got, 0); return; end
    e = exp_q.pop_front();
    chk(got == e, req, "byte", got, e);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic wait_hi(ref logic s);
    do @(negedge clk); while (!s);
  endtask
  task automatic wait_lo(ref logic s);
    do @(negedge clk); while (s);
  endtask

  // driver: host write when requested; optionally record expectation
  task automatic host_write(input logic [7:0] v, input bit with_eop, input bit push);
    do @(negedge clk); while (!(drq || ready));
    if (push) exp_q.push_back(v);
    dack = 1; wr_stb = 1; host_wdata = v; eop = with_eop;
    @(negedge clk);
    dack = 0; wr_stb = 0; eop = 0;
    chk(!drq && !ready, "R5", "request after write", {drq, ready}, 0);
  endtask

  task automatic host_read(input int n, input bit blk);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!(drq || ready));
      chk(blk ? (ready && !drq) : (drq && !ready), "R6", "throttle line", {drq, ready}, blk ? 1 : 2);
      sb_pop(host_rdata, "R3");
      dack = 1; rd_stb = 1;
      @(negedge clk);
      dack = 0; rd_stb = 0;
      chk(!drq && !ready, "R5", "request after read", {drq, ready}, 0);
    end
  endtask

  // bench as initiator receiving from a target-mode DUT
  task automatic peer_init_recv(input int n);
    for (int i = 0; i < n; i++) begin
      wait_hi(req_out);
      sb_pop(bus_data_out, "R1");
      repeat (2) @(negedge clk);
      chk(req_out, "R1", "REQ held until ACK", req_out, 1);
      ack_in = 1;
      wait_lo(req_out);
      repeat (3) @(negedge clk);
      chk(!req_out, "R1", "no new REQ while ACK high", req_out, 0);
      ack_in = 0;
    end
  endtask

  // bench as initiator sending to a target-mode DUT
  task automatic peer_init_send(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      wait_hi(req_out);
      bus_data_in = base + 8'(i);
      exp_q.push_back(bus_data_in);
      @(negedge clk); ack_in = 1;
      wait_lo(req_out);
      bus_data_in = 8'hEE;
      ack_in = 0;
    end
  endtask

  // bench as target sending to an initiator-mode DUT
  task automatic peer_tgt_send(input int n, input logic [7:0] base);
    int lat;
    for (int i = 0; i < n; i++) begin
      bus_data_in = base + 8'(i);
      exp_q.push_back(bus_data_in);
      @(negedge clk); req_in = 1;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!ack_out);
      chk(lat >= 2, "R2", "ACK after synchronised REQ", lat, 2);
      bus_data_in = 8'h55;
      req_in = 0;
      @(negedge clk);
      chk(ack_out, "R2", "ACK held until REQ low seen", ack_out, 1);
      wait_lo(ack_out);
    end
  endtask

  // bench as target receiving from an initiator-mode DUT
  task automatic peer_tgt_recv(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!bus_drive);
      @(negedge clk); req_in = 1;
      wait_hi(ack_out);
      sb_pop(bus_data_out, "R2");
      req_in = 0;
      wait_lo(ack_out);
    end
  endtask

  always @(negedge clk)
    if (rst_n && ((req_out && !cfg_target) || (ack_out && cfg_target))) role_bad++;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int quiet;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!drq && !ready && !req_out && !ack_out && !dma_on && !irq_eop, "R4", "reset state",
        {drq, ready, req_out, ack_out, dma_on, irq_eop}, 0);
    bsy_in = 1;
    repeat (4) @(negedge clk);

    // starts with DMA disabled
    pulse(start_send);
    @(negedge clk);
    chk(!drq && !ready, "R9", "start ignored while disabled", drq, 0);

    mode_val = 1; pulse(mode_wr);
    chk(dma_on, "R8", "DMA enable set", dma_on, 1);

    // role mismatch: target receive while initiator
    cfg_target = 0;
    pulse(start_trecv);
    repeat (4) @(negedge clk);
    chk(!drq && !req_out && !ack_out, "R9", "role-mismatched start ignored", {drq, req_out}, 0);

    // target send, drq throttling, last byte carries EOP
    cfg_target = 1; eop_irq_en = 1;
    pulse(start_send);
    chk(drq, "R4", "send request right after start", drq, 1);
    fork
      begin
        host_write(8'hA1, 0, 1);
        host_write(8'h5C, 0, 1);
        host_write(8'h3E, 1, 1);
      end
      peer_init_recv(3);
    join
    chk(irq_eop, "R7", "EOP interrupt", irq_eop, 1);
    chk(dma_on, "R8", "EOP keeps DMA enable", dma_on, 1);
    quiet = 0;
    repeat (20) begin @(negedge clk); if (drq || ready || req_out) quiet++; end
    chk(quiet == 0, "R7", "no cycles after EOP", quiet, 0);

    // initiator receive in block mode; stray EOP without DACK
    cfg_target = 0; cfg_block = 1;
    pulse(start_irecv);
    chk(!irq_eop, "R7", "interrupt cleared by new start", irq_eop, 0);
    pulse(eop);
    fork
      peer_tgt_send(3, 8'h70);
      host_read(3, 1);
    join
    chk(!irq_eop, "R7", "EOP without DACK ignored", irq_eop, 0);

    // target receive with drq
    cfg_target = 1; cfg_block = 0;
    pulse(start_trecv);
    fork
      peer_init_send(2, 8'hC4);
      host_read(2, 0);
    join

    // initiator send, then BSY loss mid-byte
    cfg_target = 0;
    pulse(start_send);
    fork
      begin host_write(8'h96, 0, 1); host_write(8'h0F, 0, 1); end
      peer_tgt_recv(2);
    join
    host_write(8'h44, 0, 0);
    @(negedge clk); req_in = 1;
    wait_hi(ack_out);
    bsy_in = 0;
    repeat (4) @(negedge clk);
    chk(!dma_on, "R8", "bus free clears DMA enable", dma_on, 0);
    chk(!ack_out && !drq && !ready, "R8", "bus free aborts handshake", {ack_out, drq}, 0);
    req_in = 0; bsy_in = 1;
    repeat (4) @(negedge clk);
    pulse(start_send);
    @(negedge clk);
    chk(!drq && !ready, "R9", "start ignored after bus free", drq, 0);

    chk(role_bad == 0, "R10", "role gating of REQ/ACK", role_bad, 0);
    chk(exp_q.size() == 0, "R3", "all bytes delivered", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule